// File: doc/BRIEF.md
# Serial-Input DAC Code Register Front End

This block is the digital input stage of a serial-input digital-to-analog converter. A host shifts a code in one bit at a time and then transfers it to a holding register, whose contents are the code presented to the converter. The host uses four control pins: an active-low select, a serial clock, an active-low transfer strobe and an active-low clear.

Every pin is asynchronous to the block. Each pin passes through a synchronizer in the system clock domain before any edge is detected. The select pin and the serial clock are symmetric: a rising edge on either one, while the other is low, moves the shift register by one bit. The transfer strobe copies the shift register into the holding register. While the strobe stays low, the holding register keeps following the shift register. Clear takes priority over the strobe. A sticky flag records any shift that happens while the strobe is low.

Top module: `sdac_front`

## Requirements
- R1: A rising serial clock edge while select is low shifts the data bit into bit 0 of the shift register, with the earlier bits moving up one place. The first bit of a 12-bit frame therefore ends in bit 11, which is the MSB.
- R2: A rising select edge while the serial clock is low also shifts in one data bit.
- R3: While select is high, serial clock edges leave the shift register unchanged.
- R4: A falling edge of the transfer strobe, with clear inactive, copies the shift register into the holding register.
- R5: While the transfer strobe is held low and clear is inactive, the holding register follows the shift register as it changes.
- R6: While clear is low, the holding register reads 0 whatever the strobe does. The shift register keeps its contents.
- R7: When clear is released while the strobe is high, the holding register stays at 0 until the next transfer.
- R8: When more than 12 bits are shifted in, only the 12 most recent are kept.
- R9: A shift that happens while the strobe is low sets the error flag. The flag stays set until reset.
- R10: A synchronous reset clears the shift register, the holding register and the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Serial select, active low |
| ser_clk | input | 1 | Serial clock |
| ser_data | input | 1 | Serial data |
| xfer_n | input | 1 | Transfer strobe, active low |
| clr_n | input | 1 | Holding register clear, active low |
| dac_code | output | 12 | Code held in the holding register |
| proto_err | output | 1 | Sticky flag: shift while the strobe was low |

## Verification
The bench uses the default parameters: a 12-bit code and a two-stage synchronizer. It holds each serial level for four system clocks, which is well inside the required clock ratio. With the 12-bit width, a 16-bit frame is enough to show that the oldest bits are discarded. A select edge taken while the serial clock is held low shows the select-driven shift. Each scenario reads the shift register through a transfer, so shift-register effects are checked at the code output.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int CODE_W_DEF = 12;
  localparam int N_PINS     = 5;
  localparam int P_SEL      = 0;
  localparam int P_SCLK     = 1;
  localparam int P_DATA     = 2;
  localparam int P_XFER     = 3;
  localparam int P_CLR      = 4;
  // idle levels: select high, clock high, data low, strobe high, clear high
  localparam logic [N_PINS-1:0] PIN_IDLE = 5'b11011;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int WIDTH = 5,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pins,
  output logic [WIDTH-1:0] lvl
);
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL[i]}};
        else     chain <= {chain[STAGES-2:0], pins[i]};
      end
      assign lvl[i] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/sdac_shreg.sv
module sdac_shreg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_evt,
  input  logic         din,
  output logic [W-1:0] q
);
  function automatic logic [W-1:0] push_bit(input logic [W-1:0] cur, input logic b);
    return {cur[W-2:0], b};
  endfunction

  always_ff @(posedge clk) begin
    if (rst)            q <= '0;
    else if (shift_evt) q <= push_bit(q, din);
  end

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !shift_evt |=> $stable(q));
  assert_lsb_entry_R1: assert property (@(posedge clk) disable iff (rst)
    shift_evt |=> q[0] == $past(din));
  assert_drop_oldest_R8: assert property (@(posedge clk) disable iff (rst)
    shift_evt |=> q[W-1:1] == $past(q[W-2:0]));
endmodule

// File: rtl/sdac_hold.sv
module sdac_hold #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_n_s,
  input  logic         xfer_n_s,
  input  logic         xfer_fall,
  input  logic [W-1:0] shreg,
  output logic [W-1:0] code
);
  always_ff @(posedge clk) begin
    if (rst)            code <= '0;
    else if (!clr_n_s)  code <= '0;
    else if (!xfer_n_s) code <= shreg;
  end

  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (rst)
    !clr_n_s |=> code == '0);
  assert_latched_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_n_s && xfer_n_s) |=> $stable(code));
  assert_copy_R4: assert property (@(posedge clk) disable iff (rst)
    (xfer_fall && clr_n_s) |=> code == $past(shreg));
endmodule

// File: rtl/sdac_front.sv
module sdac_front
  import sdac_pkg::*;
#(
  parameter int CODE_W = CODE_W_DEF,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              xfer_n,
  input  logic              clr_n,
  output logic [CODE_W-1:0] dac_code,
  output logic              proto_err
);
  logic [N_PINS-1:0] raw, lvl;
  logic sel_prev, sclk_prev, xfer_prev;
  logic sel_rise, sclk_rise, xfer_fall, shift_evt;
  logic [CODE_W-1:0] shreg;

  always_comb begin
    raw = '0;
    raw[P_SEL]  = sel_n;
    raw[P_SCLK] = ser_clk;
    raw[P_DATA] = ser_data;
    raw[P_XFER] = xfer_n;
    raw[P_CLR]  = clr_n;
  end

  sdac_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst(rst), .pins(raw), .lvl(lvl));

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_prev  <= PIN_IDLE[P_SEL];
      sclk_prev <= PIN_IDLE[P_SCLK];
      xfer_prev <= PIN_IDLE[P_XFER];
    end else begin
      sel_prev  <= lvl[P_SEL];
      sclk_prev <= lvl[P_SCLK];
      xfer_prev <= lvl[P_XFER];
    end
  end

  assign sel_rise  = lvl[P_SEL] & ~sel_prev;
  assign sclk_rise = lvl[P_SCLK] & ~sclk_prev;
  assign xfer_fall = ~lvl[P_XFER] & xfer_prev;
  assign shift_evt = (sclk_rise & ~lvl[P_SEL]) | (sel_rise & ~lvl[P_SCLK]);

  sdac_shreg #(.W(CODE_W)) u_shreg (
    .clk(clk), .rst(rst), .shift_evt(shift_evt), .din(lvl[P_DATA]), .q(shreg));

  sdac_hold #(.W(CODE_W)) u_hold (
    .clk(clk), .rst(rst), .clr_n_s(lvl[P_CLR]), .xfer_n_s(lvl[P_XFER]),
    .xfer_fall(xfer_fall), .shreg(shreg), .code(dac_code));

  always_ff @(posedge clk) begin
    if (rst) proto_err <= 1'b0;
    else if (shift_evt && !lvl[P_XFER]) proto_err <= 1'b1;
  end

  assert_err_set_R9: assert property (@(posedge clk) disable iff (rst)
    (shift_evt && !lvl[P_XFER]) |=> proto_err);
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);
  assert_sel_gate_R3: assert property (@(posedge clk) disable iff (rst)
    (lvl[P_SEL] && !sel_rise) |-> !shift_evt);
  assert_transparent_R5: assert property (@(posedge clk) disable iff (rst)
    (!lvl[P_XFER] && lvl[P_CLR]) |=> dac_code == $past(shreg));
endmodule

// File: tb/tb_sdac_front.sv
module tb_sdac_front;
  logic clk = 0, rst = 1;
  logic sel_n = 1, ser_clk = 1, ser_data = 0, xfer_n = 1, clr_n = 1;
  logic [11:0] dac_code;
  logic proto_err;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  sdac_front dut (.clk(clk), .rst(rst), .sel_n(sel_n), .ser_clk(ser_clk),
    .ser_data(ser_data), .xfer_n(xfer_n), .clr_n(clr_n),
    .dac_code(dac_code), .proto_err(proto_err));

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [15:0] w, input int n);
    sel_n = 0; wait_clk(6);
    for (int i = n - 1; i >= 0; i--) begin
      ser_clk = 0; ser_data = w[i]; wait_clk(4);
      ser_clk = 1; wait_clk(4);
    end
    sel_n = 1; wait_clk(6);
  endtask

  task automatic pulse_xfer();
    xfer_n = 0; wait_clk(8);
    xfer_n = 1; wait_clk(8);
  endtask

  task automatic t_reset();
    check("R10 code", dac_code, 12'h000);
    check("R10 err", {11'b0, proto_err}, 12'h000);
  endtask

  task automatic t_frame();
    send_bits(16'h0A5C, 12);
    check("R4 before transfer", dac_code, 12'h000);
    pulse_xfer();
    check("R1 R4 frame", dac_code, 12'hA5C);
    send_bits(16'h0800, 12);
    pulse_xfer();
    check("R1 msb first", dac_code, 12'h800);
    check("R9 no err", {11'b0, proto_err}, 12'h000);
  endtask

  task automatic t_overflow();
    send_bits(16'hABCD, 16);
    pulse_xfer();
    check("R8 last 12 kept", dac_code, 12'hBCD);
  endtask

  task automatic t_sel_ignore();
    ser_data = 1;
    for (int i = 0; i < 5; i++) begin
      ser_clk = 0; wait_clk(4); ser_clk = 1; wait_clk(4);
    end
    pulse_xfer();
    check("R3 clock ignored", dac_code, 12'hBCD);
  endtask

  task automatic t_sel_shift();
    ser_clk = 0; ser_data = 1; wait_clk(4);
    sel_n = 0; wait_clk(6);
    sel_n = 1; wait_clk(6);
    ser_clk = 1; wait_clk(6);
    pulse_xfer();
    check("R2 select edge shift", dac_code, 12'h79B);
  endtask

  task automatic t_clear();
    send_bits(16'h0123, 12);
    pulse_xfer();
    check("R4 load", dac_code, 12'h123);
    clr_n = 0; wait_clk(8);
    check("R6 cleared", dac_code, 12'h000);
    xfer_n = 0; wait_clk(8);
    check("R6 overrides strobe", dac_code, 12'h000);
    xfer_n = 1; wait_clk(8);
    clr_n = 1; wait_clk(8);
    check("R7 stays zero", dac_code, 12'h000);
    pulse_xfer();
    check("R6 shreg kept", dac_code, 12'h123);
  endtask

  task automatic t_transparent();
    xfer_n = 0; wait_clk(8);
    check("R5 follows", dac_code, 12'h123);
    check("R9 clear before", {11'b0, proto_err}, 12'h000);
    send_bits(16'h0F0F, 12);
    check("R5 follows shift", dac_code, 12'hF0F);
    check("R9 err set", {11'b0, proto_err}, 12'h001);
    xfer_n = 1; wait_clk(8);
    check("R9 err sticky", {11'b0, proto_err}, 12'h001);
  endtask

  task automatic t_rerst();
    rst = 1; wait_clk(3); rst = 0; wait_clk(4);
    check("R10 code", dac_code, 12'h000);
    check("R10 err", {11'b0, proto_err}, 12'h000);
    pulse_xfer();
    check("R10 shreg zero", dac_code, 12'h000);
  endtask

  initial begin
    wait_clk(4); rst = 0; wait_clk(4);
    t_reset();
    t_frame();
    t_overflow();
    t_sel_ignore();
    t_sel_shift();
    t_clear();
    t_transparent();
    t_rerst();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule